// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

The block takes event pulses from eight interrupt categories. Each category owns a status word, with one bit per event source, and a mask word of the same width. A pulse on an event input sets its status bit whatever the mask holds. The mask decides only whether that bit can raise an interrupt. Each category contributes one bit to an interrupt vector, and that bit is high while any status bit of the category has its enable bit set. While any vector bit is high, the block enables a low drive on a shared interrupt line. When no vector bit is high, the line is left floating.

Software works through a small register bus. It can write and read the eight mask words, read the vector and read a separate alarm latch. Reading the vector clears every status word, which releases the interrupt line. Inverting the acknowledge bit in the control register has the same effect. The alarm latch captures short alarm pulses and keeps them until software reads the latch, so an alarm that lasts a single cycle is not missed. An event or alarm that arrives in the same cycle as the read that clears it is kept for the next read.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset, mask word 0 reads 0xFF and mask words 1 to 7 read 0x00. The vector, the alarm latch and the control register read 0x00, and irq_oe is low.
- R2: A pulse on event bit b of category c sets status bit b of that category. The pulse is on ev_i bit c*8+b. If mask word c bit b is 1 (enabled), vector bit c is high from the next cycle on, and irq_oe is high from then on. The vector is read at address 0x8, with bit c for category c.
- R3: An event whose mask bit is 0 leaves the vector and irq_oe low, but the event stays stored. Setting the mask bit later makes the vector bit and irq_oe go high.
- R4: A read of address 0x8 returns the vector as it stood before the read. In the following cycle it clears every status word, and irq_oe drops unless a new enabled event arrived.
- R5: An event that arrives in the same cycle as a vector read is not lost, and it shows in the next vector read.
- R6: A write to the control register (address 0xA) clears every status word, as a vector read does, when its bit 0 differs from the stored acknowledge bit. A write with the same bit 0 value has no effect. The register reads back the stored acknowledge bit in bit 0.
- R7: A pulse on alarm_i bit k sets bit k of the alarm latch, read at address 0x9. The bit stays set until that address is read. An alarm pulse in the same cycle as the read stays set.
- R8: Clearing a mask bit while its status bit is set removes that bit's contribution, and irq_oe drops when no enabled status bit remains.
- R9: Mask word c is read and written at address c (0x0 to 0x7). Addresses 0xB to 0xF read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 64 | Event pulses, category c bit b at index c*8+b |
| alarm_i | input | 8 | Alarm pulses for the sticky alarm latch |
| rd_en | input | 1 | Register read strobe, one cycle |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address, combinational |
| irq_oe | output | 1 | High while the interrupt line is to be driven low |

## Verification
The properties assume that a mask write never lands in the same cycle as the event or clear whose effect they predict. They also assume that rd_en and wr_en are single-cycle strobes, with event pulses able to coincide with them. In the stimulus, mask writes always take cycles of their own, apart from events and reads. Events are placed next to vector reads and acknowledge writes only where the same-cycle case is itself under test.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CAT_N  = 8;
    localparam int WORD_N = 8;
    localparam int ADR_N  = 4;
endpackage

// File: rtl/irq_category.sv
module irq_category #(
    parameter int             W        = 8,
    parameter logic [W-1:0]   RST_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic         clr_i,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] status;
    } cat_st_t;

    cat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        st_d.status = (clr_i ? '0 : st_q.status) | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask   <= RST_MASK;
            st_q.status <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign pend_o = |(st_q.status & st_q.mask);
endmodule

// File: rtl/irq_alarm_latch.sv
module irq_alarm_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] alarm_i,
    input  logic         clr_i,
    output logic [W-1:0] latch_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } alm_st_t;

    alm_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (clr_i ? '0 : st_q.bits) | alarm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o = st_q.bits;
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl #(
    parameter int NUM_CAT = irq_pkg::CAT_N,
    parameter int WORD_W  = irq_pkg::WORD_N,
    parameter int ADDR_W  = irq_pkg::ADR_N
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CAT*WORD_W-1:0] ev_i,
    input  logic [WORD_W-1:0]         alarm_i,
    input  logic                      rd_en,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata,
    output logic                      irq_oe
);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(NUM_CAT);
    localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(NUM_CAT + 1);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(NUM_CAT + 2);

    typedef struct packed {
        logic ack;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_CAT-1:0]         vec;
    logic [WORD_W-1:0]          mask_w [NUM_CAT];
    logic [NUM_CAT*WORD_W-1:0]  mask_flat;
    logic [WORD_W-1:0]          alarm_q;
    logic                       ack_q;
    logic                       vec_clr;
    logic                       alm_clr;

    // next-state of the acknowledge bit and the clear strobes
    always_comb begin
        st_d = st_q;
        vec_clr = rd_en && (addr == A_VEC);
        alm_clr = rd_en && (addr == A_ALM);
        if (wr_en && (addr == A_CTL)) begin
            st_d.ack = wdata[0];
            if (wdata[0] != st_q.ack) begin
                vec_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_q = st_q.ack;

    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
        irq_category #(
            .W        (WORD_W),
            .RST_MASK ({WORD_W{c == 0}})
        ) u_cat (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_i       (ev_i[c*WORD_W +: WORD_W]),
            .mask_we    (wr_en && (addr == ADDR_W'(c))),
            .mask_wdata (wdata),
            .clr_i      (vec_clr),
            .mask_o     (mask_w[c]),
            .pend_o     (vec[c])
        );
        assign mask_flat[c*WORD_W +: WORD_W] = mask_w[c];
    end

    irq_alarm_latch #(.W(WORD_W)) u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .alarm_i (alarm_i),
        .clr_i   (alm_clr),
        .latch_o (alarm_q)
    );

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CAT; c++) begin
            if (addr == ADDR_W'(c)) begin
                rdata = mask_w[c];
            end
        end
        if (addr == A_VEC) begin
            rdata = WORD_W'(vec);
        end else if (addr == A_ALM) begin
            rdata = alarm_q;
        end else if (addr == A_CTL) begin
            rdata = WORD_W'(st_q.ack);
        end
    end

    assign irq_oe = |vec;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int NUM_CAT = 8,
    parameter int WORD_W  = 8,
    parameter int ADDR_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rd_en,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic                      ack_wbit,
    input logic [NUM_CAT*WORD_W-1:0] ev_i,
    input logic [WORD_W-1:0]         alarm_i,
    input logic                      irq_oe,
    input logic [NUM_CAT*WORD_W-1:0] mask_flat,
    input logic [WORD_W-1:0]         alarm_q,
    input logic                      ack_q
);
    logic en_hit, mask_wr, vec_rd, ctl_wr;
    assign en_hit  = |(ev_i & mask_flat);
    assign mask_wr = wr_en && (addr < ADDR_W'(NUM_CAT));
    assign vec_rd  = rd_en && (addr == ADDR_W'(NUM_CAT));
    assign ctl_wr  = wr_en && (addr == ADDR_W'(NUM_CAT + 2));

    // R2
    enabled_event_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hit && !mask_wr) |=> irq_oe);

    // R4
    vector_read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !en_hit && !mask_wr) |=> !irq_oe);

    // R5
    event_on_read_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && en_hit && !mask_wr) |=> irq_oe);

    // R6
    ack_same_value_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ack_wbit == ack_q) && irq_oe && !vec_rd && !mask_wr) |=> irq_oe);

    // R6
    ack_toggle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ack_wbit != ack_q) && !en_hit && !mask_wr) |=> !irq_oe);

    // R7
    alarm_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|alarm_i) |=> ((alarm_q & $past(alarm_i)) == $past(alarm_i)));
endmodule

bind irq_vec_ctl irq_ctl_chk #(
    .NUM_CAT (NUM_CAT),
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .ack_wbit  (wdata[0]),
    .ev_i      (ev_i),
    .alarm_i   (alarm_i),
    .irq_oe    (irq_oe),
    .mask_flat (mask_flat),
    .alarm_q   (alarm_q),
    .ack_q     (ack_q)
);

// File: tb/tb_irq_vec_ctl.sv
module tb_irq_vec_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ev_i = '0;
    logic [7:0]  alarm_i = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_oe;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q [$];

    always #5 clk = ~clk;

    irq_vec_ctl dut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .alarm_i(alarm_i),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_oe(irq_oe)
    );

    function automatic logic [63:0] evb(input int cat, input int b);
        return 64'd1 << (cat * 8 + b);
    endfunction

    // driver: applies one cycle of stimulus, pushes the expected read value
    task automatic cyc(input logic r, input logic w, input logic [3:0] a,
                       input logic [7:0] d, input logic [63:0] e,
                       input logic [7:0] al, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        rd_en = r; wr_en = w; addr = a; wdata = d; ev_i = e; alarm_i = al;
        if (r) begin
            it.exp = exp;
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic idle();
        cyc(0, 0, 4'h0, 8'h00, 64'd0, 8'h00, 8'h00, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        cyc(1, 0, a, 8'h00, 64'd0, 8'h00, exp, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(0, 1, a, d, 64'd0, 8'h00, 8'h00, "");
    endtask

    task automatic ev(input logic [63:0] e);
        cyc(0, 0, 4'h0, 8'h00, e, 8'h00, 8'h00, "");
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq_oe !== exp) begin
            errors++;
            $display("FAIL %s: irq_oe got %b expected %b", tag, irq_oe, exp);
        end
    endtask

    // monitor: compares read data mid-cycle
    always @(negedge clk) begin
        if (rd_en) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata got %h expected %h", it.tag, rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        chk_irq(1'b0, "R1 irq after reset");
        rd(4'h0, 8'hFF, "R1 mask0");
        rd(4'h3, 8'h00, "R1 mask3");
        rd(4'h8, 8'h00, "R1 vector");
        rd(4'h9, 8'h00, "R1 alarm latch");
        rd(4'hA, 8'h00, "R1 control");

        ev(evb(0, 2));
        idle();
        chk_irq(1'b1, "R2 enabled event");
        rd(4'h8, 8'h01, "R2 vector cat0");
        idle();
        chk_irq(1'b0, "R4 released after read");
        rd(4'h8, 8'h00, "R4 vector cleared");

        ev(evb(3, 1));
        idle();
        chk_irq(1'b0, "R3 masked event");
        wr(4'h3, 8'h02);
        idle();
        chk_irq(1'b1, "R3 stored event shows once enabled");
        rd(4'h8, 8'h08, "R3 vector cat3");
        idle();
        chk_irq(1'b0, "R4 released");

        wr(4'h0, 8'h00);
        ev(evb(0, 5));
        idle();
        chk_irq(1'b0, "R3 mask0 cleared");
        wr(4'h0, 8'hFF);
        idle();
        chk_irq(1'b1, "R3 mask0 reenabled");
        wr(4'h0, 8'h00);
        idle();
        chk_irq(1'b0, "R8 mask cleared releases");
        rd(4'h8, 8'h00, "R8 vector gated by mask");
        wr(4'h0, 8'hFF);
        idle();
        chk_irq(1'b0, "R4 read cleared status");

        wr(4'h7, 8'h01);
        cyc(1, 0, 4'h8, 8'h00, evb(7, 0), 8'h00, 8'h00, "R5 read with event");
        idle();
        chk_irq(1'b1, "R5 event kept");
        rd(4'h8, 8'h80, "R5 vector cat7");

        ev(evb(0, 0));
        idle();
        chk_irq(1'b1, "R6 pending");
        wr(4'hA, 8'h00);
        idle();
        chk_irq(1'b1, "R6 same value no effect");
        wr(4'hA, 8'h01);
        idle();
        chk_irq(1'b0, "R6 toggle clears");
        ev(evb(0, 1));
        idle();
        chk_irq(1'b1, "R6 pending again");
        wr(4'hA, 8'h01);
        idle();
        chk_irq(1'b1, "R6 same value 1 no effect");
        rd(4'hA, 8'h01, "R6 ack readback");
        wr(4'hA, 8'h00);
        idle();
        chk_irq(1'b0, "R6 toggle back clears");
        rd(4'hA, 8'h00, "R6 ack readback 0");

        cyc(0, 0, 4'h0, 8'h00, 64'd0, 8'h05, 8'h00, "");
        idle(); idle(); idle();
        rd(4'h9, 8'h05, "R7 alarm sticky");
        cyc(1, 0, 4'h9, 8'h00, 64'd0, 8'h20, 8'h00, "R7 read cleared");
        rd(4'h9, 8'h20, "R7 alarm on read kept");
        rd(4'h9, 8'h00, "R7 cleared again");

        wr(4'hC, 8'h55);
        rd(4'hC, 8'h00, "R9 unmapped reads zero");
        rd(4'h1, 8'h00, "R9 mask1 untouched");
        wr(4'h5, 8'hA5);
        rd(4'h5, 8'hA5, "R9 mask5 readback");
        rd(4'h0, 8'hFF, "R9 mask0 readback");

        wr(4'h1, 8'hFF);
        wr(4'h6, 8'hFF);
        ev(evb(1, 7) | evb(6, 0));
        idle();
        rd(4'h8, 8'h42, "R2 two categories");
        idle();
        chk_irq(1'b0, "R4 released after multi");
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule